// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits beside a two-port memory. It compares the two ports' enables and addresses every cycle. When both ports are enabled on the same word, it picks one port to proceed. The other port gets an active-low busy indication, and any write that port attempts is blocked. The decision uses only the enables and addresses. Whether an access is a read or a write plays no part in it. The first port to settle on the contested address wins. A port settles on an address in the cycle its enable rises, or when it moves to a new address while enabled. If both settle in the same cycle, the left port wins. Once a grant is made, it stays in place for as long as the collision lasts.

A mode input sets the role of the busy pins, for arrays built wider than one part. In master mode the block arbitrates and drives its busy outputs. In slave mode the arbiter is disabled and its busy outputs stay high. A separate active-low busy input per port then acts only as a write inhibit. A master's busy outputs feed these inputs on each slave, so every slice of a wide word blocks the same port. The per-port write qualifiers are meant to gate the memory array's write strobes.

Top module: `dpa_busy_arbiter`

## Requirements
- R1: In master mode, when either enable is low or the addresses differ, both `l_busy_n` and `r_busy_n` are 1.
- R2: In master mode, when the addresses match with both enables high, no grant is held from the previous cycle, and the left port was already enabled on this address in the previous clock while the right port was not (its enable rose, or its address changed), then `r_busy_n` is 0 and `l_busy_n` is 1.
- R3: Under the same conditions with the roles swapped (the right port settled first), `l_busy_n` is 0 and `r_busy_n` is 1.
- R4: In master mode, when a collision begins with both ports settling in the same cycle, or with neither port newly settled (for example right after a switch into master mode), the left port wins: `r_busy_n` is 0.
- R5: `l_busy_n` and `r_busy_n` are never 0 in the same cycle.
- R6: The write inputs `l_wr` and `r_wr` have no effect on `l_busy_n` or `r_busy_n`.
- R7: While master mode and the collision both persist from one cycle to the next, both busy outputs keep their previous values.
- R8: After a cycle with no collision, or a cycle in slave mode, the next collision is decided afresh by R2 to R4.
- R9: In master mode, `l_wr_ok` = `l_en & l_wr & l_busy_n`, and `r_wr_ok` = `r_en & r_wr & r_busy_n`.
- R10: In slave mode (`master_mode` = 0), both busy outputs are 1 whatever the ports do.
- R11: In slave mode, `l_wr_ok` = `l_en & l_wr & l_busy_in_n`, and `r_wr_ok` = `r_en & r_wr & r_busy_in_n`. A low busy input blocks every write from its port.
- R12: During and right after synchronous reset, no grant and no settled address are remembered. With both ports idle, both busy outputs are 1 and both write qualifiers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = busy inputs act as write inhibits |
| l_en | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port word address |
| r_en | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in_n | input | 1 | Left write inhibit from a master, active low, used in slave mode |
| r_busy_in_n | input | 1 | Right write inhibit from a master, active low, used in slave mode |
| l_busy_n | output | 1 | Left busy indication, active low |
| r_busy_n | output | 1 | Right busy indication, active low |
| l_wr_ok | output | 1 | Left write qualifier for the array |
| r_wr_ok | output | 1 | Right write qualifier for the array |

## Verification
Some rules hold on every cycle, and the assertions check those:
- the two busy outputs are never low together;
- both busy outputs stay high when there is no collision and in slave mode;
- the write qualifiers drop whenever the active busy source for their port is low;
- a grant does not move while a collision lasts.

Which port wins a fresh collision depends on the order in which the ports settled over earlier cycles, so only the bench's scenarios can show it. The bench drives:
- staggered arrivals from each side;
- simultaneous arrivals;
- one port moving onto the other's address;
- toggled write levels;
- a mode switch.

It then compares each outcome against a model of the arrival order.

// File: rtl/dpa_pkg.sv
// Shared types for the address-match busy arbiter.
package dpa_pkg;
    // Which port currently owns a contested address.
    typedef enum logic [1:0] {
        GRANT_NONE  = 2'd0,
        GRANT_LEFT  = 2'd1,
        GRANT_RIGHT = 2'd2
    } grant_e;

    localparam int unsigned NPORT = 2;
    localparam int unsigned PORT_L = 0;
    localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/dpa_arrival_track.sv
// Arrival tracker for one port.
// Flags the cycle in which a port newly settles on an address: its enable
// rose, or its address changed while enabled. Assumes that the enable and
// address are sampled once per clock. Reset clears the memory, so a port
// that is enabled right after reset counts as newly arrived.
module dpa_arrival_track #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    logic              prev_en;
    logic [ADDR_W-1:0] prev_addr;

    // Remember the enable and address seen at the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= en;
            prev_addr <= addr;
        end
    end

    // A port is new this cycle if it was idle before or has moved.
    always_comb begin
        fresh = en && (!prev_en || (addr != prev_addr));
    end
endmodule

// File: rtl/dpa_grant_ctrl.sv
// Grant controller.
// Decides which port owns a contested address. It holds the decision for as
// long as the collision lasts in master mode, and clears it otherwise. A fresh
// decision favours the port that did not just arrive, and the left port on a
// tie. Assumes that match and the arrival flags are valid in the same cycle.
module dpa_grant_ctrl
    import dpa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   arb_on,
    input  logic   match,
    input  logic   l_fresh,
    input  logic   r_fresh,
    output grant_e winner
);
    grant_e held_q;
    grant_e fresh_pick;

    // Pick a winner from arrival order; the port that came later loses.
    always_comb begin
        if (l_fresh && !r_fresh) begin
            fresh_pick = GRANT_RIGHT;
        end else begin
            fresh_pick = GRANT_LEFT;
        end
    end

    // A held grant has priority over a new pick while the collision lasts.
    always_comb begin
        if (!(arb_on && match)) begin
            winner = GRANT_NONE;
        end else if (held_q != GRANT_NONE) begin
            winner = held_q;
        end else begin
            winner = fresh_pick;
        end
    end

    // Keep the grant across a collision and drop it once the collision ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= GRANT_NONE;
        end else begin
            held_q <= winner;
        end
    end
endmodule

// File: rtl/dpa_write_gate.sv
// Write qualifier for one port.
// Passes a write to the array only when the port is enabled, requests a write,
// and is not busy. In master mode the arbiter's own busy output is the
// source; in slave mode the external inhibit input is. Purely combinational.
module dpa_write_gate (
    input  logic master_mode,
    input  logic en,
    input  logic wr,
    input  logic busy_out_n,
    input  logic busy_in_n,
    output logic wr_ok
);
    logic clear_to_write;

    // Choose the busy source for the current mode.
    always_comb begin
        clear_to_write = master_mode ? busy_out_n : busy_in_n;
    end

    // Qualify the write with enable, request and busy state.
    always_comb begin
        wr_ok = en && wr && clear_to_write;
    end
endmodule

// File: rtl/dpa_busy_arbiter.sv
// Address-match busy arbiter (top).
// Compares both ports' enables and addresses. In master mode it grants a
// contested word to one port, drives active-low busy to the other, and blocks
// that port's writes. In slave mode the busy outputs stay high, and the
// external busy inputs act as write inhibits. Assumes both ports share one
// clock. The read/write level never enters the arbitration.
module dpa_busy_arbiter
    import dpa_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic [NPORT-1:0]             en_v;
    logic [NPORT-1:0]             wr_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0]             busy_in_v;
    logic [NPORT-1:0]             busy_out_v;
    logic [NPORT-1:0]             fresh_v;
    logic [NPORT-1:0]             wr_ok_v;
    logic                         match;
    grant_e                       winner;

    // Gather per-port signals into vectors for the replicated logic.
    always_comb begin
        en_v[PORT_L]      = l_en;
        en_v[PORT_R]      = r_en;
        wr_v[PORT_L]      = l_wr;
        wr_v[PORT_R]      = r_wr;
        addr_v[PORT_L]    = l_addr;
        addr_v[PORT_R]    = r_addr;
        busy_in_v[PORT_L] = l_busy_in_n;
        busy_in_v[PORT_R] = r_busy_in_n;
    end

    // Detect a collision: both enabled on the same word.
    always_comb begin
        match = l_en && r_en && (l_addr == r_addr);
    end

    // One arrival tracker and one write gate per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_arrival_track #(
            .ADDR_W (ADDR_W)
        ) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
        );

        dpa_write_gate u_gate (
            .master_mode (master_mode),
            .en          (en_v[p]),
            .wr          (wr_v[p]),
            .busy_out_n  (busy_out_v[p]),
            .busy_in_n   (busy_in_v[p]),
            .wr_ok       (wr_ok_v[p])
        );
    end

    dpa_grant_ctrl u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .arb_on  (master_mode),
        .match   (match),
        .l_fresh (fresh_v[PORT_L]),
        .r_fresh (fresh_v[PORT_R]),
        .winner  (winner)
    );

    // Busy goes low on the port that did not win; high in slave mode.
    always_comb begin
        busy_out_v[PORT_L] = !(winner == GRANT_RIGHT);
        busy_out_v[PORT_R] = !(winner == GRANT_LEFT);
    end

    // Drive the top-level outputs.
    always_comb begin
        l_busy_n = busy_out_v[PORT_L];
        r_busy_n = busy_out_v[PORT_R];
        l_wr_ok  = wr_ok_v[PORT_L];
        r_wr_ok  = wr_ok_v[PORT_R];
    end
endmodule

// File: rtl/dpa_busy_arbiter_chk.sv
// Property checker for the busy arbiter, attached to the top by bind.
// Looks only at the top-level ports.
module dpa_busy_arbiter_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_en,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_en,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic collide;
    logic past_ok;

    // Collision as seen from the pins.
    always_comb begin
        collide = l_en && r_en && (l_addr == r_addr);
    end

    // Marks that at least one full cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    assert_idle_no_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !collide) |-> (l_busy_n && r_busy_n));

    assert_slave_no_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n));

    assert_master_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> ((!l_busy_n -> !l_wr_ok) && (!r_busy_n -> !r_wr_ok)));

    assert_slave_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> ((!l_busy_in_n -> !l_wr_ok) && (!r_busy_in_n -> !r_wr_ok)));

    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && master_mode && collide && $past(master_mode && collide))
        |-> (l_busy_n == $past(l_busy_n) && r_busy_n == $past(r_busy_n)));
endmodule

bind dpa_busy_arbiter dpa_busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_wr        (l_wr),
    .l_addr      (l_addr),
    .r_en        (r_en),
    .r_wr        (r_wr),
    .r_addr      (r_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_ok     (l_wr_ok),
    .r_wr_ok     (r_wr_ok)
);

// File: tb/dpa_busy_arbiter_test.sv
// Bench for the busy arbiter: directed corners, then seeded random traffic,
// all checked against a model of arrival order.
module dpa_busy_arbiter_test;
    localparam int unsigned ADDR_W     = 15;
    localparam int          CLK_PERIOD = 10;
    localparam int          N_RANDOM   = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              master_mode = 1'b1;
    logic              l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic              l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic              l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

    int checks = 0;
    int errors = 0;

    // Model state: previous inputs and held grant (0 none, 1 left, 2 right).
    logic              m_l_en = 1'b0, m_r_en = 1'b0;
    logic [ADDR_W-1:0] m_l_addr = '0, m_r_addr = '0;
    int                m_held = 0;

    dpa_busy_arbiter #(.ADDR_W(ADDR_W)) uut (
        .clk (clk), .rst_n (rst_n), .master_mode (master_mode),
        .l_en (l_en), .l_wr (l_wr), .l_addr (l_addr),
        .r_en (r_en), .r_wr (r_wr), .r_addr (r_addr),
        .l_busy_in_n (l_busy_in_n), .r_busy_in_n (r_busy_in_n),
        .l_busy_n (l_busy_n), .r_busy_n (r_busy_n),
        .l_wr_ok (l_wr_ok), .r_wr_ok (r_wr_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic f_match();
        return l_en && r_en && (l_addr == r_addr);
    endfunction

    function automatic int f_winner();
        logic lf, rf;
        if (!(master_mode && f_match())) return 0;
        if (m_held != 0) return m_held;
        lf = l_en && (!m_l_en || l_addr != m_l_addr);
        rf = r_en && (!m_r_en || r_addr != m_r_addr);
        return (lf && !rf) ? 2 : 1;
    endfunction

    task automatic check1(input string tag, input string what,
                          input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive inputs (already set), compare outputs, then clock the model.
    task automatic step(input string tag);
        int   w;
        logic eb_l, eb_r, eok_l, eok_r;
        #1;
        w     = f_winner();
        eb_l  = (w != 2);
        eb_r  = (w != 1);
        eok_l = l_en && l_wr && (master_mode ? eb_l : l_busy_in_n);
        eok_r = r_en && r_wr && (master_mode ? eb_r : r_busy_in_n);
        check1(tag, "l_busy_n", l_busy_n, eb_l);
        check1(tag, "r_busy_n", r_busy_n, eb_r);
        check1(tag, "l_wr_ok",  l_wr_ok,  eok_l);
        check1(tag, "r_wr_ok",  r_wr_ok,  eok_r);
        @(posedge clk);
        if (!rst_n) begin
            m_l_en = 1'b0; m_r_en = 1'b0; m_l_addr = '0; m_r_addr = '0; m_held = 0;
        end else begin
            m_held = w;
            m_l_en = l_en; m_r_en = r_en; m_l_addr = l_addr; m_r_addr = r_addr;
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic le, input logic lw, input int la,
                         input logic re, input logic rw, input int ra);
        l_en = le; l_wr = lw; l_addr = ADDR_W'(la);
        r_en = re; r_wr = rw; r_addr = ADDR_W'(ra);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        @(negedge clk);
        // R12: reset state with idle ports.
        step("R12");
        step("R12");
        rst_n = 1'b1;
        step("R12");

        // R2: left settles first, right joins later; writes toggle (R6, R9).
        drive(1, 1, 16'h7ffe, 0, 0, 0);  step("R2");
        drive(1, 1, 16'h7ffe, 1, 1, 16'h7ffe); step("R2");
        drive(1, 0, 16'h7ffe, 1, 1, 16'h7ffe); step("R7");
        drive(1, 1, 16'h7ffe, 1, 0, 16'h7ffe); step("R6");
        drive(0, 1, 16'h7ffe, 1, 1, 16'h7ffe); step("R1");
        // R3 and R8: left returns after right has been sitting there.
        drive(1, 1, 16'h7ffe, 1, 1, 16'h7ffe); step("R3");
        drive(1, 1, 16'h7ffe, 1, 1, 16'h7ffe); step("R7");
        // R1: addresses differ.
        drive(1, 1, 16'h0010, 1, 1, 16'h0011); step("R1");
        // R2: right moves onto left's address.
        drive(1, 1, 16'h0010, 1, 1, 16'h0010); step("R2");
        // R4: both idle, then arrive together.
        drive(0, 0, 0, 0, 0, 0); step("R1");
        drive(1, 1, 16'h0123, 1, 1, 16'h0123); step("R4");
        drive(1, 1, 16'h0123, 1, 1, 16'h0123); step("R8");
        // R10, R11: slave mode during a collision.
        master_mode = 1'b0;
        l_busy_in_n = 1'b0; r_busy_in_n = 1'b1; step("R10");
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b0; step("R11");
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b1; step("R11");
        // R4: back to master with both already settled; left wins.
        master_mode = 1'b1; step("R4");
        step("R7");

        // Random traffic on a small address set to provoke collisions.
        for (int i = 0; i < N_RANDOM; i++) begin
            string tag;
            master_mode = ($urandom_range(0, 9) != 0);
            l_en        = ($urandom_range(0, 3) != 0);
            r_en        = ($urandom_range(0, 3) != 0);
            l_wr        = 1'($urandom_range(0, 1));
            r_wr        = 1'($urandom_range(0, 1));
            l_addr      = ADDR_W'($urandom_range(0, 2) + 16'h7ffc);
            r_addr      = ADDR_W'($urandom_range(0, 2) + 16'h7ffc);
            l_busy_in_n = ($urandom_range(0, 2) != 0);
            r_busy_in_n = ($urandom_range(0, 2) != 0);
            if (!master_mode)       tag = "R11";
            else if (!f_match())    tag = "R1";
            else if (m_held != 0)   tag = "R7";
            else                    tag = "R8";
            step(tag);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule